// File: doc/BRIEF.md
# Floating-Point Status and Exception Unit

This block holds the status and control word that governs a floating-point datapath. Software writes the word through a load port. The block then drives two controls to the arithmetic: truncating rounding and flushing of denormals to zero. After each arithmetic operation, the datapath reports five exception conditions on an update port: invalid, divide-by-zero, overflow, underflow and inexact. The block records them in the word.

Each report replaces the per-operation flag field. A report that raises at least one flag also ORs those flags into a sticky cause field. That cause field is then tested against a software-written enable field. If any enabled cause is present, a one-cycle trap request with a fixed 12-bit exception code goes to the core. A compare that ends unordered reports through the same port as every other operation, so its invalid flag can trap as well.

Top module: `fp_status_unit`

## Requirements
- R1: After reset the status word, `trapReq`, `trapCode`, `roundToZero` and `flushDenorm` are all zero.
- R2: A load stores `loadData` ANDed with a mask of bits 18:0, one cycle later. Bits 31:19 of `statusWord` always read zero.
- R3: `roundToZero` is high exactly when the rounding field (bits 1:0) holds 01. The encodings 00, 10 and 11 all select round-to-nearest-even (`roundToZero` low).
- R4: `flushDenorm` follows bit 18 of the status word.
- R5: An update replaces the flag field (bits 6:2) with `excFlags` in the cycle after the strobe. `excFlags` bit 0 = inexact maps to word bit 2, bit 1 = underflow to bit 3, bit 2 = overflow to bit 4, bit 3 = divide-by-zero to bit 5, and bit 4 = invalid to bit 6.
- R6: An update with any flag set ORs `excFlags` into cause bits 16:12, in the same order as R5 (inexact at bit 12). Cause bit 17 and all other cause bits keep their values.
- R7: An update with all flags clear leaves the cause and enable fields unchanged and raises no trap. The flag field still becomes zero.
- R8: After an update with any flag set, a trap is raised when the new cause bits 16:12 ANDed with the enable bits 11:7 are non-zero. The enable bits use the R5 order (inexact at bit 7). A raised trap is `trapReq` high for the one cycle after the strobe, with `trapCode` = 0x120. In every other cycle `trapReq` is low and `trapCode` is 0.
- R9: When `loadEn` and `updEn` are both high in the same cycle, the load is applied and the update is dropped. A load never raises a trap.
- R10: Updates never change the rounding field or bit 18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadEn | input | 1 | Software write strobe |
| loadData | input | 32 | Value to write |
| updEn | input | 1 | Operation-complete strobe from the datapath |
| excFlags | input | 5 | Exception flags of the completed operation (R5 order) |
| statusWord | output | 32 | Current status/control word |
| roundToZero | output | 1 | Truncating rounding selected |
| flushDenorm | output | 1 | Flush denormals to zero |
| trapReq | output | 1 | One-cycle trap request |
| trapCode | output | 12 | Exception code, 0x120 during a trap |

## Verification
The bench steps through each of the four rounding encodings to catch a decoder that tests only one bit of the rounding field. It sends a flag-free update after causes have built up; a design that cleared the cause field or re-tested old causes would then corrupt the word or raise a trap. It raises a trap through a cause left over from an earlier operation, which a design that tested only the new flags would miss. Finally, it drives load and update together, where a wrong priority would show up as changed flags or a false trap.

// File: rtl/fpsu_pkg.sv
package fpsu_pkg;
  localparam int N_FLAGS   = 5;
  localparam int RM_LSB    = 0;
  localparam int RM_W      = 2;
  localparam int FLAG_LSB  = 2;
  localparam int EN_LSB    = FLAG_LSB + N_FLAGS;
  localparam int CAUSE_LSB = EN_LSB + N_FLAGS;
  localparam int CAUSE_W   = N_FLAGS + 1;
  localparam int DN_BIT    = CAUSE_LSB + CAUSE_W;
  localparam int USED_W    = DN_BIT + 1;
  localparam logic [RM_W-1:0] RM_TRUNC = 2'b01;

  typedef struct packed {
    logic doLoad;
    logic doUpdate;
    logic anyFlag;
  } fpsuStrobes_t;
endpackage

// File: rtl/fpsu_ctrl.sv
module fpsu_ctrl
  import fpsu_pkg::*;
(
  input  logic               loadEn,
  input  logic               updEn,
  input  logic [N_FLAGS-1:0] excFlags,
  output fpsuStrobes_t       strobes
);
  // Load has priority over a same-cycle update (R9).
  always_comb begin
    strobes.doLoad   = loadEn;
    strobes.doUpdate = updEn && !loadEn;
    strobes.anyFlag  = updEn && !loadEn && (|excFlags);
  end
endmodule

// File: rtl/fpsu_datapath.sv
module fpsu_datapath
  import fpsu_pkg::*;
#(
  parameter int                 DATA_W      = 32,
  parameter int                 CODE_W      = 12,
  parameter logic [CODE_W-1:0]  TRAP_VECTOR = 12'h120
) (
  input  logic               clk,
  input  logic               rstN,
  input  fpsuStrobes_t       strobes,
  input  logic [DATA_W-1:0]  loadData,
  input  logic [N_FLAGS-1:0] excFlags,
  output logic [DATA_W-1:0]  statusWord,
  output logic               roundToZero,
  output logic               flushDenorm,
  output logic               trapReq,
  output logic [CODE_W-1:0]  trapCode
);
  localparam logic [DATA_W-1:0] WR_MASK = {{(DATA_W-USED_W){1'b0}}, {USED_W{1'b1}}};

  logic [DATA_W-1:0]  statusQ, statusD;
  logic [N_FLAGS-1:0] newCause;
  logic               trapD, trapQ;
  logic [CODE_W-1:0]  codeQ;

  // Cause accumulation, one bit per flag.
  for (genvar i = 0; i < N_FLAGS; i++) begin : g_cause
    assign newCause[i] = statusQ[CAUSE_LSB+i] | excFlags[i];
  end

  always_comb begin
    statusD = statusQ;
    trapD   = 1'b0;
    if (strobes.doLoad) begin
      statusD = loadData & WR_MASK;
    end else if (strobes.doUpdate) begin
      statusD[FLAG_LSB +: N_FLAGS] = excFlags;
      if (strobes.anyFlag) begin
        statusD[CAUSE_LSB +: N_FLAGS] = newCause;
        trapD = |(newCause & statusQ[EN_LSB +: N_FLAGS]);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      trapQ   <= 1'b0;
      codeQ   <= '0;
    end else begin
      statusQ <= statusD;
      trapQ   <= trapD;
      codeQ   <= trapD ? TRAP_VECTOR : '0;
    end
  end

  assign statusWord  = statusQ;
  assign roundToZero = (statusQ[RM_LSB +: RM_W] == RM_TRUNC);
  assign flushDenorm = statusQ[DN_BIT];
  assign trapReq     = trapQ;
  assign trapCode    = codeQ;

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    statusQ[DATA_W-1:USED_W] == '0);

  a_r6_cause_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.doUpdate) |->
      ((statusQ[CAUSE_LSB +: CAUSE_W] & $past(statusQ[CAUSE_LSB +: CAUSE_W]))
        == $past(statusQ[CAUSE_LSB +: CAUSE_W])));

  a_r7_quiet_update: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.doUpdate && !strobes.anyFlag) |->
      (!trapQ && $stable(statusQ[DN_BIT:EN_LSB])));

  a_r8_code_with_trap: assert property (@(posedge clk) disable iff (!rstN)
    trapQ ? (codeQ == TRAP_VECTOR) : (codeQ == '0));

  a_r9_load_no_trap: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.doLoad) |-> !trapQ);

  a_r10_controls_kept: assert property (@(posedge clk) disable iff (!rstN)
    $past(!strobes.doLoad) |->
      ($stable(statusQ[DN_BIT]) && $stable(statusQ[RM_LSB +: RM_W])));
endmodule

// File: rtl/fp_status_unit.sv
module fp_status_unit
  import fpsu_pkg::*;
#(
  parameter int                DATA_W      = 32,
  parameter int                CODE_W      = 12,
  parameter logic [CODE_W-1:0] TRAP_VECTOR = 12'h120
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadEn,
  input  logic [DATA_W-1:0]  loadData,
  input  logic               updEn,
  input  logic [N_FLAGS-1:0] excFlags,
  output logic [DATA_W-1:0]  statusWord,
  output logic               roundToZero,
  output logic               flushDenorm,
  output logic               trapReq,
  output logic [CODE_W-1:0]  trapCode
);
  fpsuStrobes_t strobes;

  fpsu_ctrl ctrl_i (
    .loadEn   (loadEn),
    .updEn    (updEn),
    .excFlags (excFlags),
    .strobes  (strobes)
  );

  fpsu_datapath #(
    .DATA_W      (DATA_W),
    .CODE_W      (CODE_W),
    .TRAP_VECTOR (TRAP_VECTOR)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .loadData    (loadData),
    .excFlags    (excFlags),
    .statusWord  (statusWord),
    .roundToZero (roundToZero),
    .flushDenorm (flushDenorm),
    .trapReq     (trapReq),
    .trapCode    (trapCode)
  );
endmodule

// File: tb/fp_status_unit_tb_top.sv
`timescale 1ns/1ps
module fp_status_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadEn = 1'b0;
  logic [31:0] loadData = '0;
  logic        updEn = 1'b0;
  logic [4:0]  excFlags = '0;
  logic [31:0] statusWord;
  logic        roundToZero, flushDenorm, trapReq;
  logic [11:0] trapCode;

  int nChk = 0;
  int nFail = 0;
  bit done = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  fp_status_unit dut_i (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadData(loadData),
    .updEn(updEn), .excFlags(excFlags), .statusWord(statusWord),
    .roundToZero(roundToZero), .flushDenorm(flushDenorm),
    .trapReq(trapReq), .trapCode(trapCode)
  );

  // Behavioural reference model.
  logic [31:0] mWord = '0;
  bit          mTrap = 0;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mWord = '0;
      mTrap = 0;
    end else begin
      mTrap = 0;
      if (loadEn) begin
        mWord = loadData & 32'h0007_FFFF;
      end else if (updEn) begin
        mWord = (mWord & ~32'h7C) | (32'(excFlags) << 2);
        if (excFlags != 0) begin
          mWord = mWord | (32'(excFlags) << 12);
          if ((((mWord >> 12) & (mWord >> 7)) & 32'h1F) != 0) mTrap = 1;
        end
      end
    end
  end

  task automatic compare();
    logic [31:0] expWord = mWord;
    bit expRtz = (mWord[1:0] == 2'b01);
    bit expDn  = mWord[18];
    logic [11:0] expCode = mTrap ? 12'h120 : 12'h000;
    nChk++;
    if (statusWord !== expWord || roundToZero !== expRtz || flushDenorm !== expDn ||
        trapReq !== mTrap || trapCode !== expCode) begin
      nFail++;
      $display("FAIL %s word=%h rtz=%b dn=%b trap=%b code=%h exp word=%h rtz=%b dn=%b trap=%b code=%h",
               tag, statusWord, roundToZero, flushDenorm, trapReq, trapCode,
               expWord, expRtz, expDn, mTrap, expCode);
    end
  endtask

  task automatic cyc(input bit ld, input logic [31:0] d, input bit up, input logic [4:0] f);
    loadEn = ld; loadData = d; updEn = up; excFlags = f;
    @(posedge clk); #1;
    loadEn = 0; updEn = 0;
    compare();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog expired");
      $display("  %0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    #9;
    tag = "R1"; compare();
    rstN = 1'b1;
    #2;
    cyc(0, 0, 0, 0);
    // R2, R4: mask and denormal control
    tag = "R2"; cyc(1, 32'hFFFF_FFFF, 0, 0);
    tag = "R4"; cyc(1, 32'h0004_0000, 0, 0);
    // R3: all four rounding encodings
    tag = "R3";
    for (int e = 0; e < 4; e++) cyc(1, 32'(e), 0, 0);
    // R5, R6: walk each flag with enables clear
    tag = "R5"; cyc(1, 0, 0, 0);
    for (int i = 0; i < 5; i++) begin
      tag = (i % 2 == 0) ? "R5" : "R6";
      cyc(0, 0, 1, 5'(1 << i));
    end
    // R6: cause bit 17 kept
    tag = "R6"; cyc(1, 32'h0002_0000, 0, 0);
    cyc(0, 0, 1, 5'b00011);
    // R7: flag-free update after causes built up, with enables set
    tag = "R7"; cyc(1, 32'h0001_F000 | 32'h0000_0F80, 0, 0);
    cyc(0, 0, 1, 5'b0);
    // R8: enable divide-by-zero (bit 10), rounding truncate
    tag = "R8"; cyc(1, 32'h0000_0401, 0, 0);
    cyc(0, 0, 1, 5'b01000);
    cyc(0, 0, 0, 0);
    // R8: leftover cause traps on unrelated flag, back to back
    cyc(0, 0, 1, 5'b00001);
    cyc(0, 0, 1, 5'b00010);
    // R8: enabled flag not raised
    cyc(1, 32'h0000_0800, 0, 0);
    cyc(0, 0, 1, 5'b00111);
    // R8: invalid from unordered compare traps
    cyc(0, 0, 1, 5'b10000);
    // R10: updates keep controls
    tag = "R10"; cyc(1, 32'h0004_0001, 0, 0);
    cyc(0, 0, 1, 5'b11111);
    cyc(0, 0, 1, 5'b00000);
    // R9: load beats update, no trap
    tag = "R9"; cyc(1, 32'h0000_0F80, 0, 0);
    cyc(1, 32'h0000_0F80, 1, 5'b11111);
    cyc(0, 0, 0, 0);
    // mixed random traffic
    tag = "R8";
    for (int k = 0; k < 400; k++) begin
      int r = $urandom_range(0, 9);
      cyc(r == 0, $urandom, r != 1, 5'($urandom));
    end
    // R1: reset again mid-run
    tag = "R1";
    rstN = 1'b0; #1; compare();
    @(posedge clk); #1; compare();
    done = 1;
    $display("  %0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule